// File: doc/BRIEF.md
# Prescaled Modulus Down-Counter Timer

A 16-bit down-counter that ticks through a selectable prescaler (divide by 1, 4, 8 or 16). Each tick lowers the count by one. When the count reaches zero a sticky zero flag is raised. On the next tick the counter refills from a programmable load register, so the flag repeats with a period of (load + 1) × divisor clock cycles. The flag can drive an interrupt request when the interrupt-enable bit is set.

Software controls the block through a byte-wide register interface. Writes are single-cycle, using a write enable and a byte address. Reads are combinational on the address. A change of divisor is deferred until the next load of the count register. A force-load strobe refills the count at once and restarts the prescaler. While the timer is disabled the count is parked at 0xFFFF, so no early flag can occur when counting starts.

Top module: `mdc_timer`

## Requirements
- R1: After reset the control byte, load register and flag are 0, the count reads 0xFFFF and `irq_o` is low.
- R2: While the enable bit (control bit 3) is 0, the count is held at 0xFFFF and the flag is never set.
- R3: A control write with bit 2 set and bit 3 set copies the load register into the count and restarts the prescaler, so the next zero flag falls exactly load × divisor cycles after that write. The same write with bit 3 clear is ignored. Bit 2 always reads back as 0.
- R4: The active select code (control bits 1:0) 00, 01, 10, 11 divides the tick rate by 1, 4, 8 and 16.
- R5: Each tick lowers a nonzero count by one. The tick that brings the count to 0 sets the flag. The next tick reloads the load value, giving a flag period of (load + 1) × divisor. A load value of 0 keeps the count at 0 and sets the flag on every tick.
- R6: A select code written without a force-load takes effect only at the next reload at zero. A force-load takes its select from the same write.
- R7: The flag is bit 7 at byte offset 1. Writing 1 there clears it, and writing 0 has no effect. A set in the same cycle as a clear wins.
- R8: `irq_o` is high exactly when the flag is set and the interrupt-enable bit (control bit 4) is 1.
- R9: The byte map is: control at 0 (reads {3'b0, bit4, bit3, 0, bits1:0}), flag at 1, load low/high at 2/3, count low/high at 4/5 (read only; writes there are ignored), and 6 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Single-cycle register write strobe |
| addr_i | input | 3 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
A register write lands on the clock edge that samples it, and reads are combinational. As a result the readback, the force-load refill and a flag clear are all visible in the cycle after the write. A flag set by a tick shows on `irq_o` in the cycle after that tick's edge. So after a force-load at edge k, the flag is due at edge k + load × divisor. The flags after that follow every (load + 1) × divisor edges. The bench keeps a cycle counter tied to the posedge and compares the read port and `irq_o` with a behavioural model at every falling edge. It measures those intervals exactly, including the mixed period across a deferred divisor change.

// File: rtl/mdc_pkg.sv
package mdc_pkg;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int PCNT_W = 4;
  localparam int NBYTES = CNT_W / DATA_W;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd1;
  localparam logic [ADDR_W-1:0] A_LOAD = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;

  localparam int B_FORCE = 2;
  localparam int B_EN    = 3;
  localparam int B_IE    = 4;
  localparam int B_FLAG  = 7;

  typedef enum logic [1:0] {PS_DIV1, PS_DIV4, PS_DIV8, PS_DIV16} psel_e;

  // terminal count of the prescaler for a select code
  function automatic logic [PCNT_W-1:0] div_last(input psel_e s);
    case (s)
      PS_DIV1:  return PCNT_W'(0);
      PS_DIV4:  return PCNT_W'(3);
      PS_DIV8:  return PCNT_W'(7);
      default:  return PCNT_W'(15);
    endcase
  endfunction
endpackage

// File: rtl/mdc_regs.sv
module mdc_regs
  import mdc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              set_ev_i,
  output psel_e             sel_o,
  output logic              en_o,
  output logic              ie_o,
  output logic [CNT_W-1:0]  load_o,
  output logic              flag_o,
  output logic              force_ld_o,
  output psel_e             force_sel_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic ctrl_wr, flag_clr;

  assign ctrl_wr     = wr_en_i && (addr_i == A_CTRL);
  assign flag_clr    = wr_en_i && (addr_i == A_FLAG) && wdata_i[B_FLAG];
  assign force_ld_o  = ctrl_wr && wdata_i[B_FORCE] && wdata_i[B_EN];
  assign force_sel_o = psel_e'(wdata_i[1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o <= PS_DIV1;
      en_o  <= 1'b0;
      ie_o  <= 1'b0;
    end else if (ctrl_wr) begin
      sel_o <= psel_e'(wdata_i[1:0]);
      en_o  <= wdata_i[B_EN];
      ie_o  <= wdata_i[B_IE];
    end
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_load
    localparam logic [ADDR_W-1:0] LA = ADDR_W'(int'(A_LOAD) + b);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     load_o[b*DATA_W +: DATA_W] <= '0;
      else if (wr_en_i && addr_i == LA) load_o[b*DATA_W +: DATA_W] <= wdata_i;
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_o <= 1'b0;
    else if (set_ev_i) flag_o <= 1'b1;
    else if (flag_clr) flag_o <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL) begin
      rdata_o[1:0]  = sel_o;
      rdata_o[B_EN] = en_o;
      rdata_o[B_IE] = ie_o;
    end
    if (addr_i == A_FLAG) rdata_o[B_FLAG] = flag_o;
    for (int b = 0; b < NBYTES; b++) begin
      if (addr_i == ADDR_W'(int'(A_LOAD) + b)) rdata_o = load_o[b*DATA_W +: DATA_W];
      if (addr_i == ADDR_W'(int'(A_CNT) + b))  rdata_o = cnt_i[b*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/mdc_prescaler.sv
module mdc_prescaler
  import mdc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              restart_i,
  input  psel_e             act_sel_i,
  output logic              tick_o,
  output logic [PCNT_W-1:0] pcnt_o
);
  assign tick_o = en_i && (pcnt_o == div_last(act_sel_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pcnt_o <= '0;
    else if (restart_i || !en_i) pcnt_o <= '0;
    else if (tick_o)             pcnt_o <= '0;
    else                         pcnt_o <= pcnt_o + PCNT_W'(1);
  end
endmodule

// File: rtl/mdc_counter.sv
module mdc_counter
  import mdc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             force_ld_i,
  input  psel_e            force_sel_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] load_i,
  input  psel_e            sel_i,
  output logic [CNT_W-1:0] cnt_o,
  output psel_e            act_sel_o,
  output logic             set_ev_o
);
  logic at_zero;

  assign at_zero  = (cnt_o == '0);
  assign set_ev_o = en_i && !force_ld_i && tick_i &&
                    ((cnt_o == CNT_W'(1)) || (at_zero && load_i == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o     <= '1;
      act_sel_o <= PS_DIV1;
    end else if (force_ld_i) begin
      cnt_o     <= load_i;
      act_sel_o <= force_sel_i;
    end else if (!en_i) begin
      cnt_o     <= '1;
    end else if (tick_i) begin
      if (at_zero) begin
        cnt_o     <= load_i;
        act_sel_o <= sel_i;
      end else begin
        cnt_o     <= cnt_o - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/mdc_timer.sv
module mdc_timer
  import mdc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  psel_e             sel_q, act_sel, force_sel;
  logic              en_q, ie_q, flag_q, force_ld, tick, set_ev;
  logic [CNT_W-1:0]  load_q, cnt_q;
  logic [PCNT_W-1:0] pcnt_q;

  mdc_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .cnt_i(cnt_q), .set_ev_i(set_ev),
    .sel_o(sel_q), .en_o(en_q), .ie_o(ie_q), .load_o(load_q), .flag_o(flag_q),
    .force_ld_o(force_ld), .force_sel_o(force_sel), .rdata_o
  );

  mdc_prescaler u_presc (
    .clk_i, .rst_ni, .en_i(en_q), .restart_i(force_ld),
    .act_sel_i(act_sel), .tick_o(tick), .pcnt_o(pcnt_q)
  );

  mdc_counter u_cnt (
    .clk_i, .rst_ni, .en_i(en_q), .force_ld_i(force_ld), .force_sel_i(force_sel),
    .tick_i(tick), .load_i(load_q), .sel_i(sel_q),
    .cnt_o(cnt_q), .act_sel_o(act_sel), .set_ev_o(set_ev)
  );

  assign irq_o = flag_q && ie_q;
endmodule

// File: rtl/mdc_timer_chk.sv
module mdc_timer_chk
  import mdc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              irq_o,
  input logic              en_q,
  input logic              ie_q,
  input logic              flag_q,
  input logic              force_ld,
  input logic              tick,
  input logic              set_ev,
  input logic [CNT_W-1:0]  load_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [PCNT_W-1:0] pcnt_q,
  input psel_e             sel_q,
  input psel_e             act_sel
);
  logic clr_wr;
  assign clr_wr = wr_en_i && addr_i == A_FLAG && wdata_i[B_FLAG];

  a_r2_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !force_ld) |=> (cnt_q == '1 && !flag_q || cnt_q == '1));
  a_r2_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !set_ev);
  a_r3_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_ld |=> (cnt_q == $past(load_q) && pcnt_q == '0));
  a_r5_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !force_ld && tick && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  a_r5_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !force_ld && tick && cnt_q == '0) |=> cnt_q == $past(load_q));
  a_r6_defer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(force_ld || (en_q && tick && cnt_q == '0)) |=> $stable(act_sel));
  a_r6_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !force_ld && tick && cnt_q == '0) |=> act_sel == $past(sel_q));
  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_ev |=> flag_q);
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && !set_ev) |=> !flag_q);
  a_r8_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_q && ie_q));
endmodule

bind mdc_timer mdc_timer_chk u_chk (
  .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .irq_o,
  .en_q, .ie_q, .flag_q, .force_ld, .tick, .set_ev,
  .load_q, .cnt_q, .pcnt_q, .sel_q, .act_sel
);

// File: tb/mdc_timer_tb_top.sv
`timescale 1ns/1ps
module mdc_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [2:0] addr = 3'd4;
  logic [7:0] wd = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mdc_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .addr_i(addr),
    .wdata_i(wd), .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model
  int m_cnt, m_pc, m_sel, m_asel, m_load;
  bit m_en, m_ie, m_flag;

  function automatic int divof(input int s);
    case (s)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic logic [7:0] m_read(input int a);
    case (a)
      0: return 8'((m_ie << 4) | (m_en << 3) | m_sel);
      1: return 8'(m_flag << 7);
      2: return 8'(m_load % 256);
      3: return 8'(m_load / 256);
      4: return 8'(m_cnt % 256);
      5: return 8'(m_cnt / 256);
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 65535; m_pc = 0; m_sel = 0; m_asel = 0; m_load = 0;
      m_en = 0; m_ie = 0; m_flag = 0;
    end else begin
      bit fl, tk, st, cl;
      int n_cnt, n_pc, n_asel;
      cyc++;
      fl = wr && addr == 0 && wd[2] && wd[3];
      tk = m_en && (m_pc == divof(m_asel) - 1);
      st = m_en && !fl && tk && (m_cnt == 1 || (m_cnt == 0 && m_load == 0));
      cl = wr && addr == 1 && wd[7];
      n_cnt = m_cnt; n_asel = m_asel;
      if (fl) begin n_cnt = m_load; n_asel = wd[1:0]; end
      else if (!m_en) n_cnt = 65535;
      else if (tk) begin
        if (m_cnt == 0) begin n_cnt = m_load; n_asel = m_sel; end
        else n_cnt = m_cnt - 1;
      end
      n_pc = (fl || !m_en || tk) ? 0 : m_pc + 1;
      m_flag = st ? 1'b1 : (cl ? 1'b0 : m_flag);
      if (wr && addr == 0) begin m_sel = wd[1:0]; m_en = wd[3]; m_ie = wd[4]; end
      if (wr && addr == 2) m_load = (m_load / 256) * 256 + wd;
      if (wr && addr == 3) m_load = wd * 256 + (m_load % 256);
      m_cnt = n_cnt; m_pc = n_pc; m_asel = n_asel;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // per-clock comparison against the model (R9 readback, R8 irq, R5 count)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R9/R5 read port vs model", rdata, m_read(addr));
      check("R8 irq vs model", irq, m_flag && m_ie);
    end
  end

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); #1; wr = 1'b1; addr = a; wd = d;
    @(negedge clk); #1; wr = 1'b0; addr = 3'd4; wd = 8'h00;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    #1; addr = a; #1;
    check(req, rdata, exp);
    addr = 3'd4;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic wait_irq(output int t);
    do begin @(negedge clk); #1; end while (!irq);
    t = cyc;
  endtask

  task automatic period(input string req, input logic [7:0] ctrl, input int exp_first,
                        input int exp_per);
    int k, t1, t2;
    bus_wr(3'd0, ctrl);
    k = cyc;
    bus_wr(3'd1, 8'h80);
    wait_irq(t1);
    check(req, t1 - k, exp_first);
    bus_wr(3'd1, 8'h80);
    wait_irq(t2);
    check(req, t2 - t1, exp_per);
    bus_wr(3'd1, 8'h80);
  endtask

  initial begin
    int ta, tb, tc;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check("R1 irq after reset", irq, 0);
    rd_chk("R1 ctrl reset", 3'd0, 8'h00);
    rd_chk("R1 flag reset", 3'd1, 8'h00);
    rd_chk("R1 load low reset", 3'd2, 8'h00);
    rd_chk("R1 count low reset", 3'd4, 8'hFF);
    rd_chk("R1 count high reset", 3'd5, 8'hFF);
    rst_n = 1'b1;
    idle(2);

    // R9 count is read only
    bus_wr(3'd4, 8'h12);
    bus_wr(3'd5, 8'h34);
    rd_chk("R9 count write ignored", 3'd4, 8'hFF);
    rd_chk("R9 count write ignored", 3'd5, 8'hFF);
    rd_chk("R9 unmapped reads 0", 3'd6, 8'h00);
    // R3 force without enable is ignored; R2 parked
    bus_wr(3'd2, 8'h03);
    bus_wr(3'd0, 8'h04);
    rd_chk("R3 force ignored when disabled", 3'd4, 8'hFF);
    rd_chk("R3 force bit reads 0", 3'd0, 8'h00);
    idle(20);
    rd_chk("R2 no flag while disabled", 3'd1, 8'h00);

    // R5/R3/R4 div4, load 3: first flag at 12, period 16
    period("R5 div4 load3", 8'h1D, 12, 16);
    rd_chk("R3 ctrl readback force 0", 3'd0, 8'h19);

    // R6 deferred switch to div16 without force
    bus_wr(3'd0, 8'h1B);
    wait_irq(ta); bus_wr(3'd1, 8'h80);
    wait_irq(tb); bus_wr(3'd1, 8'h80);
    wait_irq(tc); bus_wr(3'd1, 8'h80);
    check("R6 new divisor after reload", tc - tb, 64);
    check("R6 old divisor still active before reload", ((tb - ta) == 64) ? 1 : 0, 0);

    // R3 force restarts prescaler mid-count
    idle(7);
    period("R3 force div16", 8'h1F, 48, 64);
    // R4 other codes
    period("R4 div8", 8'h1E, 24, 32);
    period("R4 div1", 8'h1C, 3, 4);

    // R5 load 0: count stays 0, flag every tick; R7 set wins over clear
    bus_wr(3'd2, 8'h00);
    bus_wr(3'd0, 8'h1C);
    idle(3);
    rd_chk("R5 load0 holds 0", 3'd4, 8'h00);
    bus_wr(3'd1, 8'h80);
    rd_chk("R7 set wins over clear", 3'd1, 8'h80);

    // R7 write 0 no effect, write 1 clears; R8 irq gated
    bus_wr(3'd2, 8'hC8);
    bus_wr(3'd0, 8'h1C);
    bus_wr(3'd1, 8'h00);
    rd_chk("R7 write 0 keeps flag", 3'd1, 8'h80);
    bus_wr(3'd0, 8'h08);
    check("R8 irq off when disabled bit4", irq, 0);
    bus_wr(3'd0, 8'h18);
    check("R8 irq on with flag", irq, 1);
    bus_wr(3'd1, 8'h80);
    rd_chk("R7 write 1 clears", 3'd1, 8'h00);
    check("R8 irq low after clear", irq, 0);

    // R2 disable parks the count
    bus_wr(3'd0, 8'h10);
    rd_chk("R2 parked low", 3'd4, 8'hFF);
    rd_chk("R2 parked high", 3'd5, 8'hFF);
    idle(300);
    rd_chk("R2 no flag while parked", 3'd1, 8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule